// File: doc/BRIEF.md
# Bridge Master Retry Limiter and Bus-Error Reporter

This block sits on the master side of a bus bridge and supervises one outgoing access at a time. A request is accepted only while nothing is outstanding. The block then watches the responses that come back for that access. A normal completion finishes it. A target retry leaves it pending, so the access is tried again. A bus error ends it at once. Every retry received for the same access is counted. Once the count goes past a programmable limit, the access is given up and reported as a timeout. A limit of zero turns the give-up off, and the access is then retried without end.

Bus errors are recorded separately for reads and for writes. The flags are kept in two status registers, one read by the internal host and one read by the external host, and the block drives one interrupt toward each host. The internal status register also holds a retry-timeout flag. Every flag has its own mask bit, and every flag is cleared by writing a one to it. A small register port gives access to the limit, the two status registers and the masks.

Top module: `brg_retry_guard`

## Requirements
- R1: A request (`req_valid`) is accepted only while `req_ready` is high, which is whenever `busy` is low; `busy` rises on the following clock edge. A request made while `busy` is high is ignored and does not change the direction of the pending access.
- R2: Response code 2'b00 or 2'b11 on `rsp_kind` ends the pending access normally. One cycle later `done_valid` is high for one cycle with `done_status` = 2'b00, and `busy` is low. Responses received while idle are ignored.
- R3: With a nonzero limit L (register 0), the first L retries (code 2'b01) of an access keep it pending. Retry L+1 abandons it: `done_status` = 2'b01 (timeout), `busy` clears, and bit 2 of the internal status register sets.
- R4: With a limit of 0, retries never abandon the access. It stays pending until a completion or a bus error arrives.
- R5: The retry count restarts at zero for every new access, whether the previous access completed, failed or was abandoned.
- R6: A bus error (code 2'b10) ends the access with `done_status` = 2'b10. For a read it sets bit 0 of both the internal status register (address 1) and the external status register (address 2). For a write it sets bit 1 of both.
- R7: Status bits are cleared by writing a one to them at their address. If a clear and a new set of the same bit fall in the same cycle, the bit stays set.
- R8: `irq_int` is high while any internal status bit is set and its mask bit (register 3, bits 2:0) is clear. `irq_ext` is high while any external status bit is set and its mask bit (register 3, bits 5:4) is clear. A mask bit of 1 suppresses its flag.
- R9: After reset, `busy`, `done_valid`, both interrupts, the limit, the status registers and the masks are all zero. The limit and the masks read back as they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Start a new access |
| req_write | input | 1 | Direction of the new access: 1 for write, 0 for read |
| req_ready | output | 1 | High when a new access can be accepted |
| busy | output | 1 | An access is pending |
| rsp_valid | input | 1 | A response is present for the pending access |
| rsp_kind | input | 2 | Response code: 00 ok, 01 retry, 10 bus error, 11 ok |
| done_valid | output | 1 | One-cycle pulse when the access ends |
| done_status | output | 2 | How the access ended: 00 ok, 01 timeout, 10 bus error |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address: 0 limit, 1 internal status, 2 external status, 3 masks |
| cfg_wdata | input | DW | Register write data |
| cfg_rdata | output | DW | Register read data for `cfg_addr`, combinational |
| irq_int | output | 1 | Interrupt toward the internal host |
| irq_ext | output | 1 | Interrupt toward the external host |

## Verification
In a single cycle, a status bit can be set by an ending access while software writes a one to clear that same bit. The bench forces this collision on purpose. It drives a bus error or an abandoning retry in the same cycle as a clear of the flag that the response raises. It then reads both status registers and both interrupts, and each must show the flag still set. The bench also drives random clears and random responses so that they overlap at random, and compares every readback against a model in which a new set always wins over a clear.

// File: rtl/brg_retry_guard.sv
module brg_retry_guard #(
  parameter int LIMIT_W = 8,
  parameter int DW      = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  output logic          req_ready,
  output logic          busy,
  input  logic          rsp_valid,
  input  logic [1:0]    rsp_kind,
  output logic          done_valid,
  output logic [1:0]    done_status,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  output logic          irq_int,
  output logic          irq_ext
);

  logic               busy_q, wr_q;
  logic [LIMIT_W-1:0] limit_q, rcnt;
  logic [2:0]         st_int, msk_int;
  logic [1:0]         st_ext, msk_ext;

  wire take    = req_valid & ~busy_q;
  wire got     = busy_q & rsp_valid;
  wire fin_ok  = got & ~(rsp_kind[1] ^ rsp_kind[0]);
  wire retry   = got & (rsp_kind == 2'b01);
  wire berr    = got & (rsp_kind == 2'b10);
  wire give_up = retry & (limit_q != '0) & (rcnt >= limit_q);
  wire ends    = fin_ok | berr | give_up;

  wire [2:0] set_int = {give_up, berr & wr_q, berr & ~wr_q};
  wire [1:0] set_ext = {berr & wr_q, berr & ~wr_q};
  wire [2:0] clr_int = (cfg_we && cfg_addr == 2'd1) ? cfg_wdata[2:0] : 3'b000;
  wire [1:0] clr_ext = (cfg_we && cfg_addr == 2'd2) ? cfg_wdata[1:0] : 2'b00;

  assign req_ready = ~busy_q;
  assign busy      = busy_q;
  assign irq_int   = |(st_int & ~msk_int);
  assign irq_ext   = |(st_ext & ~msk_ext);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      wr_q   <= 1'b0;
      rcnt   <= '0;
    end else if (take) begin
      busy_q <= 1'b1;
      wr_q   <= req_write;
      rcnt   <= '0;
    end else if (ends) begin
      busy_q <= 1'b0;
      rcnt   <= '0;
    end else if (retry && rcnt != '1) begin
      rcnt   <= rcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_valid  <= 1'b0;
      done_status <= 2'b00;
    end else begin
      done_valid  <= ends;
      done_status <= berr ? 2'b10 : give_up ? 2'b01 : 2'b00;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limit_q <= '0;
      msk_int <= '0;
      msk_ext <= '0;
      st_int  <= '0;
      st_ext  <= '0;
    end else begin
      st_int <= (st_int & ~clr_int) | set_int;
      st_ext <= (st_ext & ~clr_ext) | set_ext;
      if (cfg_we && cfg_addr == 2'd0) limit_q <= cfg_wdata[LIMIT_W-1:0];
      if (cfg_we && cfg_addr == 2'd3) begin
        msk_int <= cfg_wdata[2:0];
        msk_ext <= cfg_wdata[5:4];
      end
    end
  end

  always_comb begin
    case (cfg_addr)
      2'd0:    cfg_rdata = DW'(limit_q);
      2'd1:    cfg_rdata = DW'(st_int);
      2'd2:    cfg_rdata = DW'(st_ext);
      default: cfg_rdata = DW'({msk_ext, 1'b0, msk_int});
    endcase
  end

endmodule

module brg_retry_guard_chk #(
  parameter int LIMIT_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               busy,
  input logic               rsp_valid,
  input logic [1:0]         rsp_kind,
  input logic               done_valid,
  input logic [1:0]         done_status,
  input logic [LIMIT_W-1:0] limit_q,
  input logic [LIMIT_W-1:0] rcnt,
  input logic               wr_q,
  input logic [2:0]         st_int,
  input logic [1:0]         st_ext,
  input logic [2:0]         msk_int,
  input logic               irq_int
);

  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid) |=> busy);

  p_ok_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rsp_valid && rsp_kind == 2'b00) |=> (done_valid && done_status == 2'b00 && !busy));

  p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> !busy);

  p_timeout_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rsp_valid && rsp_kind == 2'b01 && limit_q != '0 && rcnt >= limit_q)
    |=> (done_status == 2'b01 && st_int[2]));

  p_no_giveup_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rsp_valid && rsp_kind == 2'b01 && limit_q == '0) |=> busy);

  p_rd_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rsp_valid && rsp_kind == 2'b10 && !wr_q) |=> (st_int[0] && st_ext[0] && done_status == 2'b10));

  p_wr_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rsp_valid && rsp_kind == 2'b10 && wr_q) |=> (st_int[1] && st_ext[1] && done_status == 2'b10));

  p_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (msk_int == 3'b111) |-> !irq_int);

endmodule

bind brg_retry_guard brg_retry_guard_chk #(.LIMIT_W(LIMIT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy),
  .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .done_valid(done_valid),
  .done_status(done_status), .limit_q(limit_q), .rcnt(rcnt), .wr_q(wr_q),
  .st_int(st_int), .st_ext(st_ext), .msk_int(msk_int), .irq_int(irq_int)
);

// File: tb/sim_brg_retry_guard.sv
module sim_brg_retry_guard;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, req_valid, req_write, req_ready, busy;
  logic       rsp_valid, done_valid, cfg_we, irq_int, irq_ext;
  logic [1:0] rsp_kind, done_status, cfg_addr;
  logic [7:0] cfg_wdata, cfg_rdata;

  brg_retry_guard u0 (.*);

  int checks = 0, fails = 0;
  logic [7:0] m_lim, m_cnt;
  logic [2:0] m_sti, m_mi;
  logic [1:0] m_ste, m_me;
  logic       m_busy, m_wr;

  function automatic logic f_irq_int();
    return |(m_sti & ~m_mi);
  endfunction
  function automatic logic f_irq_ext();
    return |(m_ste & ~m_me);
  endfunction

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    cfg_addr = a;
    #1;
    d = cfg_rdata;
  endtask

  task automatic check_regs(string r);
    logic [7:0] d;
    rd(2'd1, d); chk(r, d, {5'b0, m_sti});
    rd(2'd2, d); chk(r, d, {6'b0, m_ste});
    chk({r, "/R8"}, irq_int, f_irq_int());
    chk({r, "/R8"}, irq_ext, f_irq_ext());
  endtask

  task automatic cfg_wr(input logic [1:0] a, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (a)
      2'd0: m_lim = d;
      2'd1: m_sti = m_sti & ~d[2:0];
      2'd2: m_ste = m_ste & ~d[1:0];
      default: begin m_mi = d[2:0]; m_me = d[5:4]; end
    endcase
  endtask

  task automatic start(input logic wr);
    chk("R1 ready", req_ready, !m_busy);
    req_valid = 1'b1; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    if (!m_busy) begin m_busy = 1'b1; m_wr = wr; m_cnt = 0; end
    chk("R1 busy", busy, 1'b1);
  endtask

  task automatic resp(input logic [1:0] k, input logic do_clr,
                      input logic [1:0] ca, input logic [7:0] cd);
    logic       e_done;
    logic [1:0] e_st;
    logic [2:0] si;
    logic [1:0] se;
    string      tag;
    e_done = 0; e_st = 0; si = 0; se = 0;
    tag = (k == 2'b01) ? (m_lim == 0 ? "R4" : "R3") : (k == 2'b10) ? "R6" : "R2";
    rsp_valid = 1'b1; rsp_kind = k;
    if (do_clr) begin cfg_we = 1'b1; cfg_addr = ca; cfg_wdata = cd; end
    @(negedge clk);
    rsp_valid = 1'b0; cfg_we = 1'b0;
    if (m_busy) begin
      if (k == 2'b10) begin
        e_done = 1; e_st = 2'b10;
        si = m_wr ? 3'b010 : 3'b001; se = m_wr ? 2'b10 : 2'b01;
      end else if (k == 2'b01) begin
        if (m_lim != 0 && m_cnt >= m_lim) begin e_done = 1; e_st = 2'b01; si = 3'b100; end
        else if (m_cnt != 8'hFF) m_cnt++;
      end else e_done = 1;
      if (e_done) begin m_busy = 0; m_cnt = 0; end
    end else tag = "R2 idle";
    if (do_clr && ca == 2'd1) m_sti = m_sti & ~cd[2:0];
    if (do_clr && ca == 2'd2) m_ste = m_ste & ~cd[1:0];
    m_sti = m_sti | si; m_ste = m_ste | se;
    chk(tag, done_valid, e_done);
    if (e_done) chk(tag, done_status, e_st);
    chk(tag, busy, m_busy);
    check_regs(do_clr ? "R7" : tag);
  endtask

  initial begin
    #1500000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'h5eed_1234));
    rst_n = 0; req_valid = 0; req_write = 0; rsp_valid = 0; rsp_kind = 0;
    cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    m_lim = 0; m_cnt = 0; m_sti = 0; m_ste = 0; m_mi = 0; m_me = 0; m_busy = 0; m_wr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    chk("R9 busy", busy, 0); chk("R9 ready", req_ready, 1);
    chk("R9 done", done_valid, 0);
    rd(2'd0, d); chk("R9 limit", d, 0);
    rd(2'd3, d); chk("R9 mask", d, 0);
    check_regs("R9");

    cfg_wr(2'd0, 8'd3); rd(2'd0, d); chk("R9 limit rb", d, 3);
    cfg_wr(2'd3, 8'h35); rd(2'd3, d); chk("R9 mask rb", d, 8'h35);
    cfg_wr(2'd3, 8'h00);

    start(0); resp(2'b00, 0, 0, 0);
    start(1); resp(2'b11, 0, 0, 0);
    resp(2'b10, 0, 0, 0);

    start(0);
    for (int i = 0; i < 3; i++) resp(2'b01, 0, 0, 0);
    resp(2'b01, 0, 0, 0);
    chk("R3 timeout flag", m_sti[2], 1);
    start(1);
    for (int i = 0; i < 2; i++) resp(2'b01, 0, 0, 0);
    resp(2'b00, 0, 0, 0);
    start(1);
    for (int i = 0; i < 3; i++) resp(2'b01, 0, 0, 0);
    chk("R5 full budget", busy, 1);
    resp(2'b01, 0, 0, 0);

    cfg_wr(2'd0, 8'd0);
    start(0);
    for (int i = 0; i < 20; i++) resp(2'b01, 0, 0, 0);
    chk("R4 still busy", busy, 1);
    resp(2'b00, 0, 0, 0);

    cfg_wr(2'd1, 8'h07); cfg_wr(2'd2, 8'h03); check_regs("R7 clear");
    start(0); start(1); resp(2'b10, 0, 0, 0);
    chk("R1 ignored dir", m_ste, 2'b01);
    start(1); resp(2'b10, 1, 2'd2, 8'h02);
    chk("R7 set wins", m_ste, 2'b11);
    cfg_wr(2'd0, 8'd1);
    start(0); resp(2'b01, 0, 0, 0); resp(2'b01, 1, 2'd1, 8'h04);
    cfg_wr(2'd3, 8'h37); check_regs("R8 masked");
    cfg_wr(2'd3, 8'h10); check_regs("R8 partial");

    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(0, 3) == 0) cfg_wr(2'd0, 8'($urandom_range(0, 4)));
      if ($urandom_range(0, 4) == 0) cfg_wr(2'd3, 8'($urandom_range(0, 255)) & 8'h37);
      start(1'($urandom_range(0, 1)));
      for (int r = $urandom_range(0, 6); r > 0; r--)
        resp(2'b01, $urandom_range(0, 3) == 0, 2'($urandom_range(1, 2)), 8'($urandom_range(0, 7)));
      if (m_busy)
        resp(2'($urandom_range(0, 3)) | 2'b00, $urandom_range(0, 2) == 0,
             2'($urandom_range(1, 2)), 8'($urandom_range(0, 7)));
      if (m_busy) resp(2'b10, 0, 0, 0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule